// File: doc/BRIEF.md
# Path Delay Skew Meter

This block checks a group of nominally identical signal paths for a delay fault. It drives one transition into every path at once. It then counts, in cycles of its clock, how long the group stays split: the window opens when the first path output shows the new level and closes when the last one does. The result is the spread between the fastest and slowest path, not the absolute delay of any single path. A wide spread points to one slow path, and a part where every path is equally slow passes.

A run starts when `clear` is released. Two internal stages delay the launch edge by two cycles to give the paths time to settle. `polarity` selects a rising or a falling launch. Each path return passes through a two-flop synchronizer before detection. When the last path arrives, the block raises `done` and holds the count until the next clear.

`fault` reports that the spread exceeds a programmable threshold, that the counter saturated, or that some path never arrived before a programmable timeout. A spread of a single cycle is never a fault, because the sampling grid can turn two nearly simultaneous arrivals into one counted cycle. A build-time option places a divide-by-two stage in front of the counter, which halves the resolution.

Top module: `skew_meter`

## Requirements
- R1: While `clear` is high, `launch` stays at the inactive level (0 when `polarity`=1, 1 when `polarity`=0). Once `clear` is released, `launch` moves to the active level on the second clock edge.
- R2: With `polarity`=1, a path has arrived when its return reads 1. After `done`, `count` equals the number of cycles between the earliest and the latest path return rising.
- R3: With `polarity`=0, a path has arrived when its return reads 0. The count is formed the same way from the falling edges.
- R4: When all returns switch in the same cycle, the run completes with `count`=0 and `done`=1.
- R5: `done` rises three cycles after the cycle in which the last return changes (two synchronizer stages plus one cycle after the count window closes). It then holds, together with `count` and `fault`, until the next clear.
- R6: On completion, `fault` is 1 when `count` is greater than `threshold`, and 0 when `count` is less than or equal to `threshold`.
- R7: A final count of exactly 1 never sets `fault`, even with `threshold`=0.
- R8: The counter stops at its all-ones value instead of wrapping, and a saturated count always sets `fault`.
- R9: If some return has not arrived `timeoutLimit` cycles after the launch, `done` and `fault` both rise.
- R10: With the divide-by-two option enabled, `count` equals the spread in cycles divided by two, rounded down, before saturation.
- R11: Asserting `clear` returns `count`, `done` and `fault` to 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement and launch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Holds the unit cleared; releasing it starts a run |
| polarity | input | 1 | 1 = rising launch, 0 = falling launch |
| threshold | input | CNT_W | Largest spread accepted without a fault |
| timeoutLimit | input | TMO_W | Cycles after launch allowed for the last arrival |
| pathRet | input | NUM_PATHS | Returns from the paths under test |
| launch | output | 1 | Transition driven into all paths |
| count | output | CNT_W | Measured spread in counter steps |
| done | output | 1 | Run complete |
| fault | output | 1 | Delay fault detected |

## Verification
The bench builds two copies with four paths each. The first uses the default 6-bit counter with no divider, so exact spreads, the threshold edges and the single-cycle exemption are visible cycle for cycle, and it saturates when one path lags by 70 cycles. The second uses a 3-bit counter with the divide-by-two stage. The same spreads of 14 to 29 cycles therefore drive it into saturation, and the halving and rounding can be checked on every vector. A stuck path with a short timeout limit covers the abort case on both copies at once.

// File: rtl/skew_meter_pkg.sv
package skew_meter_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrCnt;   // zero the counter and divider
    logic cntEn;    // count window open
  } skewStrb_t;

  typedef enum logic [1:0] {
    S_ARM   = 2'd0,
    S_WAIT  = 2'd1,
    S_COUNT = 2'd2,
    S_DONE  = 2'd3
  } skewState_t;

endpackage

// File: rtl/skew_datapath.sv
module skew_datapath
  import skew_meter_pkg::*;
#(
  parameter int NUM_PATHS = 4,
  parameter int CNT_W     = 6,
  parameter bit USE_DIV2  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 polarity,
  input  logic [NUM_PATHS-1:0] pathRet,
  input  skewStrb_t            strb,
  output logic                 anyArr,
  output logic                 allArr,
  output logic [CNT_W-1:0]     cntVal,
  output logic                 cntSat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_PATHS-1:0] syncA, syncB, arrived;
  logic [CNT_W-1:0]     cntQ;
  logic                 step;

  // Two-flop synchronizer on each return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pathRet;
      syncB <= syncA;
    end
  end

  assign arrived = polarity ? syncB : ~syncB;
  assign anyArr  = |arrived;
  assign allArr  = &arrived;

  generate
    if (USE_DIV2) begin : g_div2
      logic togQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           togQ <= 1'b0;
        else if (strb.clrCnt) togQ <= 1'b0;
        else if (strb.cntEn)  togQ <= ~togQ;
      end
      assign step = strb.cntEn & togQ;
    end else begin : g_full
      assign step = strb.cntEn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cntQ <= '0;
    else if (strb.clrCnt)          cntQ <= '0;
    else if (step && !cntSat)      cntQ <= cntQ + 1'b1;
  end

  assign cntSat = (cntQ == CNT_MAX);
  assign cntVal = cntQ;

  // R8: a full counter never wraps back
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ == CNT_MAX && !strb.clrCnt) |=> (cntQ == CNT_MAX));

  // R11: clearing zeroes the counter
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrCnt |=> (cntQ == '0));

endmodule

// File: rtl/skew_control.sv
module skew_control
  import skew_meter_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             polarity,
  input  logic [CNT_W-1:0] threshold,
  input  logic [TMO_W-1:0] timeoutLimit,
  input  logic             anyArr,
  input  logic             allArr,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntSat,
  output skewStrb_t        strb,
  output logic             launch,
  output logic             done,
  output logic             fault
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  skewState_t       state;
  logic [1:0]       stg;
  logic [TMO_W-1:0] tmoCnt;
  logic             measuring, finish, tmoHit, overThr;

  // Two-stage launch generator: serial input tied active, stages reset inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stg <= 2'b00;
    else if (clear) stg <= 2'b00;
    else            stg <= {stg[0], 1'b1};
  end

  assign launch = polarity ? stg[1] : ~stg[1];

  assign measuring = (state == S_WAIT) || (state == S_COUNT);
  assign finish    = measuring && allArr;
  assign tmoHit    = measuring && !allArr && (tmoCnt == timeoutLimit);
  assign overThr   = (cntVal > threshold) && (cntVal != CNT_ONE);

  assign strb.clrCnt = clear;
  assign strb.cntEn  = measuring && anyArr && !allArr && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_ARM;
      tmoCnt <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else if (clear) begin
      state  <= S_ARM;
      tmoCnt <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      case (state)
        S_ARM:   if (stg[1]) state <= S_WAIT;
        S_WAIT:  if (!allArr && anyArr) state <= S_COUNT;
        default: ;
      endcase
      if (measuring) tmoCnt <= tmoCnt + 1'b1;
      if (finish) begin
        state <= S_DONE;
        done  <= 1'b1;
        fault <= overThr || cntSat;
      end else if (tmoHit) begin
        state <= S_DONE;
        done  <= 1'b1;
        fault <= 1'b1;
      end
    end
  end

  // R1: launch sits at its inactive level the cycle after clear is sampled
  a_r1_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && $stable(polarity)) |=> (launch == !polarity));

  // R5: done holds until clear
  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> done);

  // R5: the result is frozen once done
  a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> $stable(cntVal));

  // R7: a single-cycle spread never reports a fault
  a_r7_one_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cntVal == CNT_ONE && !cntSat) |-> !fault);

  // R9: a fault is only ever shown together with done
  a_r9_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

endmodule

// File: rtl/skew_meter.sv
module skew_meter
  import skew_meter_pkg::*;
#(
  parameter int NUM_PATHS = 4,
  parameter int CNT_W     = 6,
  parameter int TMO_W     = 10,
  parameter bit USE_DIV2  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 polarity,
  input  logic [CNT_W-1:0]     threshold,
  input  logic [TMO_W-1:0]     timeoutLimit,
  input  logic [NUM_PATHS-1:0] pathRet,
  output logic                 launch,
  output logic [CNT_W-1:0]     count,
  output logic                 done,
  output logic                 fault
);

  skewStrb_t        strb;
  logic             anyArr, allArr, cntSat;
  logic [CNT_W-1:0] cntVal;

  skew_datapath #(
    .NUM_PATHS(NUM_PATHS),
    .CNT_W    (CNT_W),
    .USE_DIV2 (USE_DIV2)
  ) datapath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .polarity(polarity),
    .pathRet (pathRet),
    .strb    (strb),
    .anyArr  (anyArr),
    .allArr  (allArr),
    .cntVal  (cntVal),
    .cntSat  (cntSat)
  );

  skew_control #(
    .CNT_W(CNT_W),
    .TMO_W(TMO_W)
  ) control_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .polarity    (polarity),
    .threshold   (threshold),
    .timeoutLimit(timeoutLimit),
    .anyArr      (anyArr),
    .allArr      (allArr),
    .cntVal      (cntVal),
    .cntSat      (cntSat),
    .strb        (strb),
    .launch      (launch),
    .done        (done),
    .fault       (fault)
  );

  assign count = cntVal;

endmodule

// File: tb/skew_meter_tb_top.sv
module skew_meter_tb_top;

  typedef struct packed {
    logic       pol;
    logic [4:0] d0, d1, d2, d3;
    logic [5:0] thr;
    logic [5:0] expCnt;
    logic       expFlt;
    logic [2:0] expCnt2;
    logic       expFlt2;
  } vec_t;

  // second copy: 3-bit counter, divide-by-two, threshold 4
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd3,  5'd3,  5'd3,  5'd3,  6'd5,  6'd0,  1'b0, 3'd0, 1'b0},
    '{1'b1, 5'd2,  5'd5,  5'd3,  5'd4,  6'd5,  6'd3,  1'b0, 3'd1, 1'b0},
    '{1'b1, 5'd1,  5'd9,  5'd4,  5'd4,  6'd5,  6'd8,  1'b1, 3'd4, 1'b0},
    '{1'b0, 5'd6,  5'd2,  5'd2,  5'd7,  6'd5,  6'd5,  1'b0, 3'd2, 1'b0},
    '{1'b0, 5'd2,  5'd3,  5'd2,  5'd2,  6'd0,  6'd1,  1'b0, 3'd0, 1'b0},
    '{1'b1, 5'd4,  5'd2,  5'd2,  5'd2,  6'd1,  6'd2,  1'b1, 3'd1, 1'b0},
    '{1'b1, 5'd1,  5'd21, 5'd10, 5'd5,  6'd10, 6'd20, 1'b1, 3'd7, 1'b1},
    '{1'b0, 5'd30, 5'd1,  5'd15, 5'd15, 6'd40, 6'd29, 1'b0, 3'd7, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b1;
  logic       polarity = 1'b1;
  logic [5:0] threshold = '0;
  logic [9:0] timeoutLimit = 10'd1000;
  logic [3:0] pathRet = '0;
  logic       launch, done, fault;
  logic [5:0] count;
  logic       launch2, done2, fault2;
  logic [2:0] count2;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  skew_meter dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .polarity(polarity),
    .threshold(threshold), .timeoutLimit(timeoutLimit), .pathRet(pathRet),
    .launch(launch), .count(count), .done(done), .fault(fault)
  );

  skew_meter #(.NUM_PATHS(4), .CNT_W(3), .TMO_W(10), .USE_DIV2(1'b1)) dut_div_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .polarity(polarity),
    .threshold(3'd4), .timeoutLimit(timeoutLimit), .pathRet(pathRet),
    .launch(launch2), .count(count2), .done(done2), .fault(fault2)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One run: returns the negedge index (from launch) at which done was first seen
  task automatic runVec(input bit pol, input int d0, input int d1, input int d2,
                        input int d3, input int thr,
                        output int launchAt, output int doneAt);
    int d [4];
    int maxd;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    maxd = 0;
    for (int i = 0; i < 4; i++) if (d[i] > maxd) maxd = d[i];
    @(negedge clk);
    clear = 1'b1; polarity = pol; threshold = 6'(thr);
    pathRet = pol ? 4'b0000 : 4'b1111;
    repeat (3) @(negedge clk);
    clear = 1'b0;
    launchAt = 0;
    while (launch != pol && launchAt < 10) begin
      @(negedge clk);
      launchAt++;
    end
    doneAt = -1;
    for (int t = 0; t <= maxd + 8; t++) begin
      for (int i = 0; i < 4; i++) if (t >= d[i]) pathRet[i] = pol;
      if (done && doneAt < 0) doneAt = t;
      @(negedge clk);
    end
  endtask

  initial begin
    int la, da;
    // reset state
    repeat (2) @(negedge clk);
    chk("R11 reset count", int'(count), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset fault", int'(fault), 0);
    chk("R1 launch idle in clear", int'(launch), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      runVec(VECS[v].pol, int'(VECS[v].d0), int'(VECS[v].d1), int'(VECS[v].d2),
             int'(VECS[v].d3), int'(VECS[v].thr), la, da);
      chk(VECS[v].pol ? "R1/R2 launch delay" : "R1/R3 launch delay", la, 2);
      chk(VECS[v].pol ? "R2 count" : "R3 count", int'(count), int'(VECS[v].expCnt));
      chk("R6/R7 fault", int'(fault), int'(VECS[v].expFlt));
      chk("R10 divided count", int'(count2), int'(VECS[v].expCnt2));
      chk("R8 divided fault", int'(fault2), int'(VECS[v].expFlt2));
      begin
        int mx;
        mx = 0;
        if (VECS[v].d0 > mx) mx = VECS[v].d0;
        if (VECS[v].d1 > mx) mx = VECS[v].d1;
        if (VECS[v].d2 > mx) mx = VECS[v].d2;
        if (VECS[v].d3 > mx) mx = VECS[v].d3;
        chk("R5 done timing", da, mx + 3);
      end
      chk("R5 done held", int'(done), 1);
      if (v == 0) chk("R4 simultaneous count", int'(count), 0);
      if (v == 2) begin
        // R11: clear drops the finished result
        @(negedge clk); clear = 1'b1;
        @(negedge clk);
        chk("R11 clear count", int'(count), 0);
        chk("R11 clear done", int'(done), 0);
        chk("R11 clear fault", int'(fault), 0);
      end
    end

    // R8: saturation on the wide copy, threshold at its maximum
    runVec(1'b1, 0, 70, 0, 0, 63, la, da);
    chk("R8 saturated count", int'(count), 63);
    chk("R8 saturated fault", int'(fault), 1);
    chk("R10 saturated divided", int'(count2), 7);

    // R7: single-cycle spread with threshold zero, rising
    runVec(1'b1, 5, 5, 6, 5, 0, la, da);
    chk("R7 count one", int'(count), 1);
    chk("R7 no fault at one", int'(fault), 0);

    // R6: spread just above threshold
    runVec(1'b1, 2, 6, 2, 2, 3, la, da);
    chk("R6 above threshold", int'(fault), 1);

    // R9: one path stuck, short timeout
    timeoutLimit = 10'd20;
    @(negedge clk);
    clear = 1'b1; polarity = 1'b1; threshold = 6'd63; pathRet = 4'b0000;
    repeat (3) @(negedge clk);
    clear = 1'b0;
    repeat (6) @(negedge clk);
    pathRet = 4'b0111;
    repeat (15) @(negedge clk);
    chk("R9 not yet timed out", int'(done), 0);
    repeat (30) @(negedge clk);
    chk("R9 timeout done", int'(done), 1);
    chk("R9 timeout fault", int'(fault), 1);
    chk("R9 timeout done divided", int'(done2), 1);
    chk("R9 timeout fault divided", int'(fault2), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule